// File: doc/BRIEF.md
# Histogram Bin Output Formatter

This block sits at the read-out end of a histogram engine. A sweep of 24-bit bin counts arrives one bin per cycle, each marked by a valid strobe. The first bin of a sweep also carries a start marker. Each count becomes a 9-bit value. That value can drive an output bus, or it can be written into a point-wise transfer-function table.

Before narrowing, the block can replace each raw count with the cumulative count up to and including that bin. This is the curve that histogram equalization uses. A programmable shift then picks a 9-bit window out of the 24-bit value. An optional saturation mode forces the result to all ones whenever a bit above the window is set. Each result appears exactly one cycle after its bin.

Top module: `hist_out_formatter`

## Requirements
- R1: `outValid` is high in a cycle exactly when `binValid` was high in the previous clock cycle, so each result follows its bin with a latency of one cycle.
- R2: With `eqEn` low, the result is computed from the incoming `binCount` itself.
- R3: Every valid bin adds its count to a 24-bit running sum, whatever the setting of `eqEn`. With `eqEn` high, the result is computed from this sum after the current bin has been added.
- R4: A valid bin with `sweepStart` high restarts the running sum, so the sum becomes that bin's count alone.
- R5: When an addition would exceed 16777215 (0xFFFFFF), the running sum holds at 0xFFFFFF instead of wrapping.
- R6: `shiftAmt` = s, in the range 0 to 15, places bits s through s+8 of the 24-bit value on `outData[0]` through `outData[8]`.
- R7: With `satEn` high and any bit above position s+8 set, `outData` is 511.
- R8: With `satEn` low, bits above the window are dropped and the windowed bits pass through unchanged.
- R9: In a cycle with `outValid` low, `outData` keeps its previous value.
- R10: After reset, `outValid` is 0, `outData` is 0 and the running sum is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| binValid | input | 1 | The bin count on `binCount` is valid in this cycle |
| binCount | input | 24 | Count of the current bin |
| sweepStart | input | 1 | First bin of a sweep; sampled only together with `binValid` |
| eqEn | input | 1 | Output the cumulative sum instead of the raw count |
| shiftAmt | input | 4 | Position of the lowest bit of the output window |
| satEn | input | 1 | Clamp to 511 when a bit above the window is set |
| outValid | output | 1 | `outData` holds a new result |
| outData | output | 9 | Formatted 9-bit result |

## Verification
The checker assumes that the configuration inputs and `binCount` are driven to known values whenever `binValid` is high. It also assumes they are never X in the cycle just after reset. The window checks cover only raw mode, where the expected result can be formed from the inputs of the previous cycle. Cumulative behaviour is left to the bench model. The bench drives every input from time zero and changes inputs only just after a rising edge. It holds all strobes low during reset and between bins, which keeps the stimulus inside these assumptions.

// File: rtl/hist_fmt_pkg.sv
package hist_fmt_pkg;
  typedef struct packed {
    logic take;     // a valid bin is being consumed this cycle
    logic restart;  // the running sum restarts from this bin
  } fmtCtrl_t;
endpackage

// File: rtl/hist_fmt_ctrl.sv
module hist_fmt_ctrl
  import hist_fmt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     binValid,
  input  logic     sweepStart,
  output fmtCtrl_t ctrl,
  output logic     outValid
);
  always_comb begin
    ctrl.take    = binValid;
    ctrl.restart = binValid & sweepStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= binValid;
  end
endmodule

// File: rtl/hist_fmt_dp.sv
module hist_fmt_dp
  import hist_fmt_pkg::*;
#(
  parameter int COUNT_W = 24,
  parameter int OUT_W   = 9,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  fmtCtrl_t           ctrl,
  input  logic [COUNT_W-1:0] binCount,
  input  logic               eqEn,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic               satEn,
  output logic [OUT_W-1:0]   outData
);
  localparam int NUM_SHIFT = 2 ** SHIFT_W;

  logic [COUNT_W-1:0] accQ;
  logic [COUNT_W-1:0] accBase;
  logic [COUNT_W:0]   sumWide;
  logic [COUNT_W-1:0] sumSat;
  logic [COUNT_W-1:0] picked;
  logic [OUT_W-1:0]   winSel [NUM_SHIFT];
  logic [NUM_SHIFT-1:0] ovfSel;
  logic [OUT_W-1:0]   result;

  always_comb begin
    accBase = ctrl.restart ? '0 : accQ;
    sumWide = {1'b0, accBase} + {1'b0, binCount};
    sumSat  = sumWide[COUNT_W] ? '1 : sumWide[COUNT_W-1:0];
    picked  = eqEn ? sumSat : binCount;
  end

  // one window and one overflow detector per shift position
  for (genvar g = 0; g < NUM_SHIFT; g++) begin : g_win
    assign winSel[g] = picked[g +: OUT_W];
    if (g + OUT_W < COUNT_W) begin : g_hi
      assign ovfSel[g] = |picked[COUNT_W-1:g+OUT_W];
    end else begin : g_top
      assign ovfSel[g] = 1'b0;
    end
  end

  always_comb begin
    if (satEn && ovfSel[shiftAmt]) result = '1;
    else                           result = winSel[shiftAmt];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ    <= '0;
      outData <= '0;
    end else if (ctrl.take) begin
      accQ    <= sumSat;
      outData <= result;
    end
  end
endmodule

// File: rtl/hist_out_formatter.sv
module hist_out_formatter
  import hist_fmt_pkg::*;
#(
  parameter int COUNT_W = 24,
  parameter int OUT_W   = 9,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               binValid,
  input  logic [COUNT_W-1:0] binCount,
  input  logic               sweepStart,
  input  logic               eqEn,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic               satEn,
  output logic               outValid,
  output logic [OUT_W-1:0]   outData
);
  fmtCtrl_t ctrl;

  hist_fmt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .binValid(binValid), .sweepStart(sweepStart),
    .ctrl(ctrl), .outValid(outValid)
  );

  hist_fmt_dp #(.COUNT_W(COUNT_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .binCount(binCount), .eqEn(eqEn),
    .shiftAmt(shiftAmt), .satEn(satEn), .outData(outData)
  );
endmodule

// File: rtl/hist_fmt_chk.sv
module hist_fmt_chk #(
  parameter int COUNT_W = 24,
  parameter int OUT_W   = 9,
  parameter int SHIFT_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               binValid,
  input logic [COUNT_W-1:0] binCount,
  input logic               eqEn,
  input logic [SHIFT_W-1:0] shiftAmt,
  input logic               satEn,
  input logic               outValid,
  input logic [OUT_W-1:0]   outData
);
  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(binValid) |-> outValid)
    else $error("R1 valid latency");

  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(binValid) |-> !outValid)
    else $error("R1 spurious valid");

  // R2, R6, R8: raw window without saturation
  assert_raw_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(binValid && !eqEn && !satEn) |->
      outData == OUT_W'($past(binCount) >> $past(shiftAmt)))
    else $error("R8 raw window");

  assert_clamp_511_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(binValid && !eqEn && satEn && (((binCount >> shiftAmt) >> OUT_W) != 0)) |->
      (outData == {OUT_W{1'b1}}))
    else $error("R7 clamp");

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData))
    else $error("R9 hold");
endmodule

bind hist_out_formatter hist_fmt_chk #(.COUNT_W(COUNT_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)) chk_i (
  .clk(clk), .rstN(rstN), .binValid(binValid), .binCount(binCount), .eqEn(eqEn),
  .shiftAmt(shiftAmt), .satEn(satEn), .outValid(outValid), .outData(outData)
);

// File: tb/hist_out_formatter_tb_top.sv
module hist_out_formatter_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [8:0] data;
    string      tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        binValid = 1'b0;
  logic [23:0] binCount = '0;
  logic        sweepStart = 1'b0;
  logic        eqEn = 1'b0;
  logic [3:0]  shiftAmt = '0;
  logic        satEn = 1'b0;
  logic        outValid;
  logic [8:0]  outData;

  expItem_t    expQ[$];
  int          numChecks = 0;
  int          numFails = 0;
  int          numPushed = 0;
  int          numPopped = 0;
  logic [23:0] modelAcc = '0;
  logic [8:0]  lastExp = '0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hist_out_formatter dut_i (
    .clk(clk), .rstN(rstN), .binValid(binValid), .binCount(binCount),
    .sweepStart(sweepStart), .eqEn(eqEn), .shiftAmt(shiftAmt), .satEn(satEn),
    .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    numChecks++;
    if (!ok) begin
      numFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendBin(input logic [23:0] c, input bit st, input bit eq,
                         input int sh, input bit sat, input string tag);
    logic [24:0] s;
    logic [23:0] v;
    logic [23:0] w;
    expItem_t it;
    s = {1'b0, (st ? 24'd0 : modelAcc)} + {1'b0, c};
    modelAcc = s[24] ? 24'hFFFFFF : s[23:0];
    v = eq ? modelAcc : c;
    w = v >> sh;
    it.data = (sat && (w[23:9] != 0)) ? 9'h1FF : w[8:0];
    it.tag = tag;
    expQ.push_back(it);
    numPushed++;
    binValid = 1'b1; binCount = c; sweepStart = st; eqEn = eq;
    shiftAmt = 4'(sh); satEn = sat;
    @(posedge clk); #1;
    binValid = 1'b0; sweepStart = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1 unexpected valid", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          numPopped++;
          check(outData === it.data, it.tag, int'(outData), int'(it.data));
          lastExp = it.data;
        end
      end else begin
        check(outData === lastExp, "R9 hold", int'(outData), int'(lastExp));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      numFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R10 outValid", int'(outValid), 0);
    check(outData === 9'd0, "R10 outData", int'(outData), 0);
    @(posedge clk); #1;
    // R10: sum starts at zero without a sweep start
    sendBin(24'd5, 0, 1, 0, 0, "R10 sum zero");
    idle(2);
    // R2, R8: raw values, no saturation
    sendBin(24'h0001FF, 0, 0, 0, 0, "R2 raw");
    sendBin(24'h000200, 0, 0, 0, 0, "R8 drop high bits");
    sendBin(24'h000200, 0, 0, 0, 1, "R7 saturate");
    sendBin(24'h0001FF, 0, 0, 0, 1, "R7 no overflow");
    // R6: window placement
    sendBin(24'h0ABCDE, 0, 0, 4, 0, "R6 shift4");
    sendBin(24'hFF8000, 0, 0, 15, 0, "R6 shift15 ones");
    sendBin(24'h800000, 0, 0, 15, 1, "R6 shift15 msb");
    sendBin(24'h0ABCDE, 0, 0, 8, 1, "R7 shift8 overflow");
    idle(3);
    // R3, R4: cumulative sums
    sendBin(24'd10, 1, 1, 0, 0, "R4 restart");
    sendBin(24'd20, 0, 1, 0, 0, "R3 cumulative");
    sendBin(24'd30, 0, 0, 0, 0, "R3 raw while summing");
    sendBin(24'd40, 0, 1, 0, 0, "R3 sum includes raw bins");
    sendBin(24'd7, 1, 1, 0, 0, "R4 second restart");
    idle(2);
    // R5: clamp of the running sum
    sendBin(24'hFFFFF0, 1, 1, 0, 0, "R5 near max");
    sendBin(24'h000100, 0, 1, 0, 0, "R5 clamp");
    sendBin(24'h000001, 0, 1, 0, 0, "R5 stays clamped");
    sendBin(24'h000000, 0, 1, 15, 1, "R5 clamped window");
    idle(4);
    // mixed stream with gaps
    begin
      logic [31:0] lcg;
      lcg = 32'h1234_5678;
      for (int i = 0; i < 60; i++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        sendBin({8'h00, lcg[31:16]} >> lcg[3:0], (i % 20) == 0, lcg[4],
                int'(lcg[11:8]), lcg[5], "R3 mixed stream");
        if (lcg[6]) idle(1);
      end
    end
    idle(4);
    check(numPushed == numPopped, "R1 result count", numPopped, numPushed);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
    $finish;
  end
endmodule